// File: doc/BRIEF.md
# Four-Line Synchronous Serial Port

This block moves one word of 5 to 8 bits at a time over a clocked serial link of four lines: a shift clock that is driven or received, a data output, a data input and a ready line that is driven or received. The host sets the role, the clock rate, the word length, the active clock edge and the output timing through a small register port. Writing a transmit word starts a transfer. The block flags the end of the word to the host and raises an interrupt request.

As master the block divides its system clock into one of three shift rates, in the ratio 8:4:1, and drives the clock line. As slave it takes the clock from the line, passes it through a two-flop synchronizer and detects its edges. The ready line can show the transfer-active state by itself in master mode. In every other case the host drives it, and the host can always read the line.

Top module: `ser4_port`

## Requirements
- R1: After reset all readable registers are zero (status bit 5 follows `rdy_i`), and `irq`, `sck_oe` and `rdy_oe` are low.
- R2: In master mode (control bit 0 = 1) `sck_oe` is high and the clock line toggles every H system cycles, with H = 2, 4 or 16 for rate codes 0, 1 or 2 (control bits 2:1; code 3 is treated as 2). The line rests at the level of the edge-select bit whenever no transfer runs.
- R3: Length code c (control bits 4:3) gives a word of 8-c bits. Writing address 1 while idle starts a transfer that sends bits [L-1:0] of the written word MSB first, one bit per active edge, for exactly L active edges.
- R4: The bits seen on `sdi` at the active edges are assembled MSB first, and after the transfer they are read at address 1 in bits [L-1:0] with the upper bits zero.
- R5: With edge select (control bit 5) at 0 the active edge is the rising edge of the clock line. At 1 it is the falling edge, and the idle line level is high.
- R6: With direct output (control bit 6 = 0) `sdo` moves to the next bit right after an active edge. With synchronized output it holds its bit until the following inactive edge. In both modes the first bit is present from the start.
- R7: In slave mode `sck_oe` stays low. The block shifts on edges of `sck_i` seen through a two-flop synchronizer and ends the word on its L-th active edge.
- R8: When a word ends, status bit 2 and `irq` go high. Writing 1 to status bit 2 at address 2 clears both.
- R9: Writing address 1 during a transfer has no effect on the data being sent and sets status bit 3, which is cleared by writing 1 to that bit.
- R10: With master mode and control bit 7 set, `rdy_oe` is high and `rdy_o` is high exactly while a transfer runs. Otherwise `rdy_o` and `rdy_oe` follow status write bits 0 and 1. Status read bits 0, 1, 4 and 5 give those two bits, the busy state and the `rdy_i` pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 transmit, 2 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 receive, 2 status |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| sck_i | input | 1 | Clock line as received |
| sck_o | output | 1 | Clock line value to drive |
| sck_oe | output | 1 | Clock line drive enable (master) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rdy_i | input | 1 | Ready line as received |
| rdy_o | output | 1 | Ready line value to drive |
| rdy_oe | output | 1 | Ready line drive enable |
| irq | output | 1 | Word-complete interrupt request |

## Verification
As master, every rate is swept against every word length, both edge selections and both output timings. Each sweep uses different transmit and receive patterns. A wrong divider, a wrong bit count or a wrong shift order each shows up as a distinct mismatch. The value of `sdo` just after the first active edge separates direct from synchronized output. The idle line level separates the two edge choices. Slave transfers are driven at each word length and edge choice with a slow external clock. A write during a transfer carries a different word, which shows whether that write was ignored.

// File: rtl/ser4_pkg.sv
// Package: shared types and helpers for the four-line serial port.
// Assumes an 8-bit host data path; word lengths 5..8 are encoded as 8-code.
package ser4_pkg;

    localparam int WORD_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // Control register layout; bit 0 is master, bit 7 is ready-auto.
    typedef struct packed {
        logic       rdy_auto;
        logic       sync_out;
        logic       edge_inv;
        logic [1:0] len_code;
        logic [1:0] rate;
        logic       master;
    } ser4_ctrl_t;

    // Number of bits in a word for a given length code.
    function automatic logic [3:0] word_len(input logic [1:0] code);
        return 4'd8 - {2'b00, code};
    endfunction

endpackage

// File: rtl/ser4_clkgen.sv
// Module: shift-clock source and edge detector.
// Master: divides clk into a base clock while run is high; base idles low.
// Slave: synchronizes sck_i through SYNC_STAGES flops, then detects edges.
// Emits one-cycle strobes for the active (sample) and inactive (launch) edge.
// Assumes edge_inv and master stay constant during a transfer.
module ser4_clkgen #(
    parameter int HALF_BASE   = 2,
    parameter int MID_MUL     = 2,
    parameter int SLOW_MUL    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master,
    input  logic [1:0] rate,
    input  logic       edge_inv,
    input  logic       run,
    input  logic       sck_i,
    output logic       sample_stb,
    output logic       launch_stb,
    output logic       sck_lvl
);
    localparam int HALF_FAST = HALF_BASE;
    localparam int HALF_MID  = HALF_BASE * MID_MUL;
    localparam int HALF_SLOW = HALF_BASE * SLOW_MUL;
    localparam int DIV_W     = $clog2(HALF_SLOW + 1);

    logic [DIV_W-1:0]       div_q;
    logic [DIV_W-1:0]       half_lim;
    logic                   bclk_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   bclk_s;
    logic                   wrap;

    // Pick the half-period limit for the selected rate.
    always_comb begin
        case (rate)
            2'd0:    half_lim = DIV_W'(HALF_FAST - 1);
            2'd1:    half_lim = DIV_W'(HALF_MID - 1);
            default: half_lim = DIV_W'(HALF_SLOW - 1);
        endcase
    end

    assign wrap = master & run & (div_q == half_lim);

    // Master divider: count half periods and toggle the base clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            bclk_q <= 1'b0;
        end else if (!master || !run) begin
            div_q  <= '0;
            bclk_q <= 1'b0;
        end else if (wrap) begin
            div_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end

    // Slave path: synchronizer chain and previous-level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sck_i};
            prev_q <= bclk_s;
        end
    end

    assign bclk_s = sync_q[SYNC_STAGES-1] ^ edge_inv;

    // Strobe selection for the active role.
    always_comb begin
        if (master) begin
            sample_stb = wrap & ~bclk_q;
            launch_stb = wrap &  bclk_q;
        end else begin
            sample_stb =  bclk_s & ~prev_q;
            launch_stb = ~bclk_s &  prev_q;
        end
    end

    assign sck_lvl = bclk_q ^ edge_inv;

    // R2: the master base clock is low whenever no transfer runs.
    p_master_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !run) |-> !bclk_q);

endmodule

// File: rtl/ser4_shifter.sv
// Module: word shifter with bit counter and output timing select.
// Loads the transmit word left-aligned so bit L-1 leaves first, shifts sdi in
// on each sample strobe, and ends a master word on the launch edge after the
// L-th sample, or a slave word on the L-th sample itself.
// Assumes the length code stays constant during a transfer.
module ser4_shifter
    import ser4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_data,
    input  logic [1:0]        len_code,
    input  logic              sync_out,
    input  logic              master,
    input  logic              sample_stb,
    input  logic              launch_stb,
    input  logic              sdi,
    output logic              busy,
    output logic              sdo,
    output logic              done_pulse,
    output logic [WORD_W-1:0] rx_word
);
    logic [3:0]        len;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] load_word;
    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] sr_nxt;
    logic [3:0]        cnt_q;
    logic              busy_q;
    logic              out_q;
    logic [WORD_W-1:0] rx_q;
    logic              finish_m;
    logic              finish_s;

    assign len       = word_len(len_code);
    assign mask      = WORD_W'((16'd1 << len) - 16'd1);
    assign load_word = tx_data << (4'd8 - len);
    assign sr_nxt    = {sr_q[WORD_W-2:0], sdi};

    assign finish_m   = busy_q &  master & launch_stb & (cnt_q == len);
    assign finish_s   = busy_q & ~master & sample_stb & (cnt_q == len - 4'd1);
    assign done_pulse = finish_m | finish_s;

    // Shift, count and end-of-word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            out_q  <= 1'b0;
            rx_q   <= '0;
        end else if (load) begin
            sr_q   <= load_word;
            cnt_q  <= '0;
            busy_q <= 1'b1;
            out_q  <= load_word[WORD_W-1];
        end else if (busy_q) begin
            if (sample_stb && (cnt_q < len)) begin
                sr_q  <= sr_nxt;
                cnt_q <= cnt_q + 4'd1;
            end
            if (launch_stb) begin
                out_q <= sr_q[WORD_W-1];
            end
            if (done_pulse) begin
                busy_q <= 1'b0;
                rx_q   <= (master ? sr_q : sr_nxt) & mask;
            end
        end
    end

    assign busy    = busy_q;
    assign sdo     = sync_out ? out_q : sr_q[WORD_W-1];
    assign rx_word = rx_q;

    // R3: the bit counter never passes the word length.
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= len));

    // R3: a load starts a transfer.
    p_load_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy_q);

    // R8: the end of a word leaves the shifter idle.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !busy_q);

endmodule

// File: rtl/ser4_regs.sv
// Module: host register file.
// Holds the control word, ready-line software bits, the done and overrun
// flags, and forms the read mux. A transmit write while idle becomes a load
// strobe; while busy it only sets overrun. Flag set wins over clear.
module ser4_regs
    import ser4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic              busy,
    input  logic              done_pulse,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rdy_pin,
    output ser4_ctrl_t        ctrl,
    output logic              rdy_val,
    output logic              rdy_drive,
    output logic              load,
    output logic              done_flag,
    output logic [WORD_W-1:0] rd_data
);
    ser4_ctrl_t ctrl_q;
    logic       rdy_val_q;
    logic       rdy_drive_q;
    logic       done_q;
    logic       ovr_q;
    logic       tx_wr;
    logic       stat_wr;

    assign tx_wr   = wr_en & (wr_addr == ADDR_DATA);
    assign stat_wr = wr_en & (wr_addr == ADDR_STAT);
    assign load    = tx_wr & ~busy;

    // Control and ready software bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            rdy_val_q   <= 1'b0;
            rdy_drive_q <= 1'b0;
        end else if (wr_en && (wr_addr == ADDR_CTRL)) begin
            ctrl_q <= ser4_ctrl_t'(wr_data);
        end else if (stat_wr) begin
            rdy_val_q   <= wr_data[0];
            rdy_drive_q <= wr_data[1];
        end
    end

    // Sticky done and overrun flags, write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (done_pulse)                done_q <= 1'b1;
            else if (stat_wr && wr_data[2]) done_q <= 1'b0;
            if (tx_wr && busy)             ovr_q <= 1'b1;
            else if (stat_wr && wr_data[3]) ovr_q <= 1'b0;
        end
    end

    // Read mux.
    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = ctrl_q;
            ADDR_DATA: rd_data = rx_word;
            ADDR_STAT: rd_data = {2'b00, rdy_pin, busy, ovr_q, done_q,
                                  rdy_drive_q, rdy_val_q};
            default:   rd_data = '0;
        endcase
    end

    assign ctrl      = ctrl_q;
    assign rdy_val   = rdy_val_q;
    assign rdy_drive = rdy_drive_q;
    assign done_flag = done_q;

    // R9: a transmit write during a transfer raises overrun.
    p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && busy) |=> ovr_q);

    // R8: the end of a word raises the done flag.
    p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> done_q);

endmodule

// File: rtl/ser4_port.sv
// Module: top of the four-line serial port.
// Ties the register file, clock source and shifter together and forms the
// line enables and the ready-line output. Pad drivers are outside.
module ser4_port
    import ser4_pkg::*;
#(
    parameter int HALF_BASE   = 2,
    parameter int MID_MUL     = 2,
    parameter int SLOW_MUL    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    output logic       sdo,
    input  logic       sdi,
    input  logic       rdy_i,
    output logic       rdy_o,
    output logic       rdy_oe,
    output logic       irq
);
    ser4_ctrl_t        ctrl;
    logic              rdy_val;
    logic              rdy_drive;
    logic              load;
    logic              done_flag;
    logic              busy;
    logic              done_pulse;
    logic [WORD_W-1:0] rx_word;
    logic              sample_stb;
    logic              launch_stb;
    logic              sck_lvl;
    logic              rdy_auto_on;

    ser4_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .done_pulse (done_pulse),
        .rx_word    (rx_word),
        .rdy_pin    (rdy_i),
        .ctrl       (ctrl),
        .rdy_val    (rdy_val),
        .rdy_drive  (rdy_drive),
        .load       (load),
        .done_flag  (done_flag),
        .rd_data    (rd_data)
    );

    ser4_clkgen #(
        .HALF_BASE   (HALF_BASE),
        .MID_MUL     (MID_MUL),
        .SLOW_MUL    (SLOW_MUL),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .master     (ctrl.master),
        .rate       (ctrl.rate),
        .edge_inv   (ctrl.edge_inv),
        .run        (busy),
        .sck_i      (sck_i),
        .sample_stb (sample_stb),
        .launch_stb (launch_stb),
        .sck_lvl    (sck_lvl)
    );

    ser4_shifter i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .tx_data    (wr_data),
        .len_code   (ctrl.len_code),
        .sync_out   (ctrl.sync_out),
        .master     (ctrl.master),
        .sample_stb (sample_stb),
        .launch_stb (launch_stb),
        .sdi        (sdi),
        .busy       (busy),
        .sdo        (sdo),
        .done_pulse (done_pulse),
        .rx_word    (rx_word)
    );

    // Ready line: automatic busy indication in master mode, else software.
    assign rdy_auto_on = ctrl.master & ctrl.rdy_auto;
    assign rdy_o       = rdy_auto_on ? busy : rdy_val;
    assign rdy_oe      = rdy_auto_on | rdy_drive;

    assign sck_o  = sck_lvl;
    assign sck_oe = ctrl.master;
    assign irq    = done_flag;

endmodule

// File: tb/test_ser4_port.sv
// Bench: sweeps master rate x length x edge x output timing, slave length x
// edge, plus overrun, ready-line and reset cases. Expected values are derived
// from the requirements in the brief.
module test_ser4_port;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       sck_i = 1'b0;
    logic       sck_o;
    logic       sck_oe;
    logic       sdo;
    logic       sdi = 1'b0;
    logic       rdy_i = 1'b0;
    logic       rdy_o;
    logic       rdy_oe;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    ser4_port i_ser4_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sck_i   (sck_i),
        .sck_o   (sck_o),
        .sck_oe  (sck_oe),
        .sdo     (sdo),
        .sdi     (sdi),
        .rdy_i   (rdy_i),
        .rdy_o   (rdy_o),
        .rdy_oe  (rdy_oe),
        .irq     (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic int half_of(input int rate);
        return (rate == 0) ? 2 : (rate == 1) ? 4 : 16;
    endfunction

    // Master transfer with a bench-side slave model.
    task automatic m_xfer(input int rate, input int lc, input bit inv,
                          input bit syn, input logic [7:0] tx,
                          input logic [7:0] rxp, input bit poke,
                          input bit rauto);
        int L = 8 - lc;
        int H = half_of(rate);
        logic [7:0] mask = 8'((16'd1 << L) - 1);
        logic [7:0] capt = 0;
        logic [7:0] v;
        int nrise = 0;
        int cyc = 0;
        int last_cyc = 0;
        bit per_ok = 1'b1;
        logic lvl, last_lvl, prev_sdo;
        wr(2'd0, {rauto, syn, inv, 2'(lc), 2'(rate), 1'b1});
        wr(2'd2, 8'h0C);
        check("R2 master drives clock", {31'd0, sck_oe}, 1);
        check("R5 idle line level", {31'd0, sck_o}, {31'd0, inv});
        sdi = rxp[L-1];
        wr(2'd1, tx);
        prev_sdo = sdo;
        last_lvl = 1'b0;
        if (poke) begin
            wr(2'd1, ~tx);
            cyc = 2;
            rd(2'd2, v);
            check("R9 overrun flag set", {31'd0, v[3]}, 1);
            prev_sdo = sdo;
        end
        while (irq !== 1'b1 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            lvl = sck_o ^ inv;
            if (lvl !== last_lvl) begin
                if (cyc - last_cyc != H) per_ok = 1'b0;
                last_cyc = cyc;
                if (lvl) begin
                    capt = {capt[6:0], prev_sdo};
                    nrise++;
                    if (nrise == 1) begin
                        check("R6 sdo after first active edge", {31'd0, sdo},
                              {31'd0, syn ? tx[L-1] : tx[L-2]});
                        if (rauto)
                            check("R10 ready shows busy",
                                  {30'd0, rdy_oe, rdy_o}, 3);
                    end
                    if (nrise < L) sdi = rxp[L-1-nrise];
                end
            end
            last_lvl = lvl;
            prev_sdo = sdo;
        end
        check("R2 half period", {31'd0, per_ok}, 1);
        check("R3 active edge count", nrise, L);
        check("R3 sent word MSB first", capt & mask, tx & mask);
        rd(2'd1, v);
        check("R4 received word", v, rxp & mask);
        check("R8 irq at end", {31'd0, irq}, 1);
        check("R5 line back at idle level", {31'd0, sck_o}, {31'd0, inv});
        if (rauto) check("R10 ready low after end", {31'd0, rdy_o}, 0);
        wr(2'd2, 8'h0C);
        check("R8 irq cleared", {31'd0, irq}, 0);
        if (poke) begin
            rd(2'd2, v);
            check("R9 overrun cleared", {31'd0, v[3]}, 0);
        end
    endtask

    // Slave transfer driven by a bench-side master model.
    task automatic s_xfer(input int lc, input bit inv, input bit syn,
                          input logic [7:0] tx, input logic [7:0] rxp);
        int L = 8 - lc;
        logic [7:0] mask = 8'((16'd1 << L) - 1);
        logic [7:0] capt = 0;
        logic [7:0] v;
        sck_i = inv;
        wr(2'd0, {1'b0, syn, inv, 2'(lc), 2'b00, 1'b0});
        repeat (4) @(negedge clk);
        wr(2'd2, 8'h0C);
        sdi = rxp[L-1];
        wr(2'd1, tx);
        check("R7 slave leaves clock undriven", {31'd0, sck_oe}, 0);
        for (int k = 0; k < L; k++) begin
            repeat (6) @(negedge clk);
            capt = {capt[6:0], sdo};
            if (k == L - 1) begin
                rd(2'd2, v);
                check("R7 still busy before last edge", {31'd0, v[4]}, 1);
            end
            sck_i = ~inv;
            repeat (6) @(negedge clk);
            sck_i = inv;
            if (k < L - 1) sdi = rxp[L-2-k];
        end
        repeat (6) @(negedge clk);
        check("R7 slave sent word", capt & mask, tx & mask);
        rd(2'd1, v);
        check("R7 slave received word", v, rxp & mask);
        rd(2'd2, v);
        check("R8 slave done flag", {30'd0, v[4], v[2]}, 1);
        check("R8 slave irq", {31'd0, irq}, 1);
        wr(2'd2, 8'h0C);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", WD_LIMIT, WD_LIMIT);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        rd(2'd0, v); check("R1 control reset", v, 0);
        rd(2'd1, v); check("R1 receive reset", v, 0);
        rd(2'd2, v); check("R1 status reset", v, 0);
        check("R1 outputs reset", {28'd0, irq, sck_oe, rdy_oe, rdy_o}, 0);
        rdy_i = 1'b1;
        rd(2'd2, v); check("R10 ready pin readable", {31'd0, v[5]}, 1);
        rdy_i = 1'b0;

        // Master sweep over rate, length, edge and output timing.
        for (int r = 0; r < 3; r++)
            for (int lc = 0; lc < 4; lc++)
                for (int e = 0; e < 2; e++)
                    for (int s = 0; s < 2; s++) begin
                        m_xfer(r, lc, e[0], s[0], 8'hA5 ^ 8'(idx * 37),
                               8'h3C + 8'(idx * 53), 1'b0, 1'b0);
                        idx++;
                    end

        // Overrun during a slow transfer; second write must be ignored.
        m_xfer(2, 0, 1'b0, 1'b0, 8'h96, 8'h5A, 1'b1, 1'b0);
        // Automatic ready indication.
        m_xfer(1, 1, 1'b1, 1'b1, 8'h4B, 8'h29, 1'b0, 1'b1);

        // Slave sweep over length and edge.
        for (int lc = 0; lc < 4; lc++)
            for (int e = 0; e < 2; e++)
                s_xfer(lc, e[0], lc[0], 8'hC3 ^ 8'(lc * 29 + e),
                       8'h71 + 8'(lc * 17 + e * 5));

        // R10: software ready control; auto mode is not available as slave.
        wr(2'd0, 8'h80);
        wr(2'd2, 8'h03);
        check("R10 software ready high", {30'd0, rdy_oe, rdy_o}, 3);
        wr(2'd2, 8'h02);
        check("R10 software ready low", {30'd0, rdy_oe, rdy_o}, 2);
        wr(2'd2, 8'h00);
        check("R10 software ready released", {31'd0, rdy_oe}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule